// File: doc/BRIEF.md
# Run-Time Programmable Serial FIR Filter

This block is a finite impulse response filter that is built around a single signed multiplier and a single saturating adder. The filter order and the tap weights are loaded while the block runs. One tap is evaluated per clock, so the block trades throughput for area. Weights and past samples are kept in two internal single-port RAMs with registered reads. Each RAM is driven by its own address counter. The sample store is used as a ring: each new sample goes to the next higher slot, and older samples are read at falling addresses.

The block is controlled by a run enable and a mode select. Raising the run enable with the mode select high starts a load. The first word on the data bus is a don't-care, the second word is the order N, and the words after it are the weights a0 up to aN. Dropping the run enable ends the load. Raising the run enable with the mode select low starts filtering. Each sample-valid pulse presents one 1.11 signed sample. After the multiply-accumulate over N+1 taps, the block raises result-valid and holds the result on its output. Dropping the run enable leaves filtering.

Top module: `tap_mac_fir`

## Requirements
- R1: After reset, resultVld is 0 and dataOut is 0.
- R2: When runEn=1 and loadMode=1 are seen in idle, the next dataIn word is ignored. The word after that sets the order N from its low 6 bits. Each following word, while runEn stays 1, is stored as the next weight a0, a1, ... aN. The same load clears the sample history at slots 0..N to zero, and the load ends on the first cycle with runEn=0.
- R3: When runEn=1 and loadMode=0 are seen in idle, the block waits for samples. Any cycle with sampleVld=1 while it waits accepts dataIn as a new sample.
- R4: Each result is the sum over k=0..N of x[k]*a[k]. Here x[0] is the newest sample, x[k] is the sample accepted k samples earlier, and x[k] is zero for a sample not accepted since the last load. History is kept across leaving and re-entering filtering.
- R5: Each term added is bits 22..8 of the 24-bit signed product, read as a 15-bit signed value. This drops the product's top bit and its 8 lowest bits.
- R6: The 15-bit accumulator starts at zero for every sample. An addition that overflows in two's complement gives +16383 when both operands are positive and -16384 when both are negative.
- R7: dataOut equals accumulator bits 14..3.
- R8: resultVld rises exactly N+2 clock edges after the edge that accepts a sample. It stays high until the next accepted sample or until filtering is left.
- R9: sampleVld pulses that arrive while a result is being computed are ignored. This includes the cycle in which resultVld is being set.
- R10: If runEn=0 while waiting for a sample, the block returns to idle and clears resultVld. A sampleVld in that same cycle is ignored.
- R11: An input of -1.0 (0x800) followed by zeros gives the outputs -a0, -a1, ..., -aN, and then zeros.
- R12: The history ring holds exactly N+1 samples. A sample accepted more than N samples earlier has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable for load or filtering |
| loadMode | input | 1 | 1 selects weight load, 0 selects filtering |
| sampleVld | input | 1 | Sample present on dataIn |
| dataIn | input | 12 | Order, weight or sample word |
| dataOut | output | 12 | Filter result, 1.11 signed |
| resultVld | output | 1 | Result on dataOut is valid |

## Verification
Two functions can land in the same cycle: accepting a sample and leaving filtering. The bench raises sampleVld with a junk sample in the cycle where runEn falls, and again in the cycle where the last tap is summed and resultVld is being set. It judges both cases from outside the block. resultVld must drop or rise at the expected edge, and every later result must match an arithmetic model whose history never contained the junk sample.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef struct packed {
    logic orderLd;
    logic coefWe;
    logic smpWe;
    logic smpZero;
    logic coefClr;
    logic coefInc;
    logic smpClr;
    logic smpInc;
    logic smpDec;
    logic tapRd;
    logic accClr;
    logic ordySet;
    logic ordyClr;
  } fir_stb_t;
endpackage

// File: rtl/fir_spram.sv
module fir_spram #(
  parameter int WIDTH = 12,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runEn,
  input  logic     loadMode,
  input  logic     sampleVld,
  input  logic     tapLast,
  output fir_stb_t stb
);
  typedef enum logic [2:0] {S_IDLE, S_ORDER, S_LOAD, S_WAIT, S_MAC, S_DRAIN} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (runEn && loadMode) stateNxt = S_ORDER;
        else if (runEn)        stateNxt = S_WAIT;
      end
      S_ORDER: begin
        if (!runEn) stateNxt = S_IDLE;
        else begin
          stb.orderLd = 1'b1;
          stb.coefClr = 1'b1;
          stb.smpClr  = 1'b1;
          stateNxt    = S_LOAD;
        end
      end
      S_LOAD: begin
        if (runEn) begin
          stb.coefWe  = 1'b1;
          stb.smpWe   = 1'b1;
          stb.smpZero = 1'b1;
          stb.coefInc = 1'b1;
          stb.smpInc  = 1'b1;
        end else begin
          stb.smpClr = 1'b1;
          stateNxt   = S_IDLE;
        end
      end
      S_WAIT: begin
        if (!runEn) begin
          stb.ordyClr = 1'b1;
          stateNxt    = S_IDLE;
        end else if (sampleVld) begin
          stb.smpWe   = 1'b1;
          stb.accClr  = 1'b1;
          stb.ordyClr = 1'b1;
          stb.coefClr = 1'b1;
          stateNxt    = S_MAC;
        end
      end
      S_MAC: begin
        stb.tapRd = 1'b1;
        if (tapLast) stateNxt = S_DRAIN;
        else begin
          stb.coefInc = 1'b1;
          stb.smpDec  = 1'b1;
        end
      end
      S_DRAIN: begin
        stb.ordySet = 1'b1;
        stateNxt    = S_WAIT;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  // R10
  exit_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !runEn) |=> state == S_IDLE);

  // R9
  busy_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MAC) |=> (state == S_MAC || state == S_DRAIN));
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 6,
  parameter int DROP_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fir_stb_t          stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              tapLast,
  output logic [DATA_W-1:0] dataOut,
  output logic              resultVld
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int TERM_W = PROD_W - 1 - DROP_LSB;
  localparam int MSB    = TERM_W - 1;
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [TERM_W-1:0] ACC_MAX = {1'b0, {(TERM_W-1){1'b1}}};
  localparam logic [TERM_W-1:0] ACC_MIN = {1'b1, {(TERM_W-1){1'b0}}};

  logic [ADDR_W-1:0] orderQ, coefCnt, smpCnt;
  logic [DATA_W-1:0] coefQ, smpQ, smpWdata;
  logic              macLive;
  logic [PROD_W-1:0] prod;
  logic [TERM_W-1:0] term, accQ, sum, satSum;
  logic              ovf;

  assign smpWdata = stb.smpZero ? '0 : dataIn;

  fir_spram #(.WIDTH(DATA_W), .AW(ADDR_W)) u_coefRam (
    .clk(clk), .we(stb.coefWe), .addr(coefCnt), .wdata(dataIn), .rdata(coefQ));

  fir_spram #(.WIDTH(DATA_W), .AW(ADDR_W)) u_smpRam (
    .clk(clk), .we(stb.smpWe), .addr(smpCnt), .wdata(smpWdata), .rdata(smpQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) orderQ <= '0;
    else if (stb.orderLd) orderQ <= dataIn[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            coefCnt <= '0;
    else if (stb.coefClr) coefCnt <= '0;
    else if (stb.coefInc) coefCnt <= coefCnt + ONE_A;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           smpCnt <= '0;
    else if (stb.smpClr) smpCnt <= '0;
    else if (stb.smpInc) smpCnt <= smpCnt + ONE_A;
    else if (stb.smpDec) smpCnt <= (smpCnt == '0) ? orderQ : smpCnt - ONE_A;
  end

  assign tapLast = (coefCnt == orderQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) macLive <= 1'b0;
    else       macLive <= stb.tapRd;
  end

  assign prod = PROD_W'($signed(coefQ) * $signed(smpQ));
  assign term = prod[PROD_W-2 -: TERM_W];
  assign sum  = accQ + term;
  assign ovf  = (accQ[MSB] == term[MSB]) && (sum[MSB] != accQ[MSB]);
  assign satSum = ovf ? (accQ[MSB] ? ACC_MIN : ACC_MAX) : sum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           accQ <= '0;
    else if (stb.accClr) accQ <= '0;
    else if (macLive)    accQ <= satSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resultVld <= 1'b0;
    else if (stb.ordySet) resultVld <= 1'b1;
    else if (stb.ordyClr) resultVld <= 1'b0;
  end

  assign dataOut = accQ[MSB -: DATA_W];

  // R6
  sat_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (macLive && accQ[MSB] == term[MSB]) |=> accQ[MSB] == $past(accQ[MSB]));

  // R12
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.smpDec && smpCnt == '0) |=> smpCnt == $past(orderQ));

  // R8
  ordy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultVld && !stb.ordyClr) |=> resultVld);

  // R8
  last_tap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultVld) |-> $past(macLive));
endmodule

// File: rtl/tap_mac_fir.sv
module tap_mac_fir
  import fir_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 6,
  parameter int DROP_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              loadMode,
  input  logic              sampleVld,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              resultVld
);
  fir_stb_t stb;
  logic     tapLast;

  fir_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loadMode(loadMode),
    .sampleVld(sampleVld), .tapLast(tapLast), .stb(stb));

  fir_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DROP_LSB(DROP_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .tapLast(tapLast), .dataOut(dataOut), .resultVld(resultVld));

  // R8
  ordy_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultVld && runEn && !sampleVld) |=> resultVld);

  // R10
  ordy_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultVld && !runEn) |=> !resultVld);
endmodule

// File: tb/tap_mac_fir_bench.sv
module tap_mac_fir_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0, loadMode = 1'b0, sampleVld = 1'b0;
  logic [11:0] dataIn = '0;
  logic [11:0] dataOut;
  logic        resultVld;

  int nChk = 0, nBad = 0;
  int coef [64];
  int hist [512];
  int histCnt = 0;
  int order = 0;
  int seed = 12345;

  always #2 clk = ~clk;

  tap_mac_fir u_tap_mac_fir (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loadMode(loadMode),
    .sampleVld(sampleVld), .dataIn(dataIn), .dataOut(dataOut), .resultVld(resultVld));

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd12();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return ((seed >> 8) & 12'hfff) - 2048;
  endfunction

  function automatic int model();
    int acc = 0;
    for (int k = 0; k <= order; k++) begin
      int x, p, t, s;
      x = (histCnt > k) ? hist[histCnt-1-k] : 0;
      p = x * coef[k];
      t = (p >>> 8) & 32'h7fff;
      if (t >= 16384) t = t - 32768;
      s = acc + t;
      if (s > 16383) s = 16383;
      if (s < -16384) s = -16384;
      acc = s;
    end
    return acc >>> 3;
  endfunction

  task automatic load_filter(input int n);
    @(negedge clk); runEn = 1; loadMode = 1; dataIn = 12'h5a5;
    @(negedge clk); dataIn = 12'(n);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk); dataIn = 12'(coef[k]);
    end
    @(negedge clk); runEn = 0; loadMode = 0; dataIn = '0;
    @(negedge clk);
    order = n; histCnt = 0;
  endtask

  task automatic enter_run();
    @(negedge clk); runEn = 1; loadMode = 0;
    @(negedge clk);
  endtask

  task automatic run_sample(input int x, input int junkAt, input string req);
    int cyc;
    dataIn = 12'(x); sampleVld = 1;
    @(negedge clk); sampleVld = 0; dataIn = 12'h3c3;
    hist[histCnt] = x; histCnt++;
    cyc = 0;
    while (!resultVld && cyc < 200) begin
      @(negedge clk); cyc++;
      sampleVld = (cyc == junkAt);
    end
    sampleVld = 0;
    chk({req, " R8 latency"}, cyc, order + 2);
    chk(req, int'($signed(dataOut)), model());
  endtask

  initial begin
    #(4ns * 150000);
    nBad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 resultVld", int'(resultVld), 0);
    chk("R1 dataOut", int'(dataOut), 0);
    rstN = 1;
    @(negedge clk);

    // R11 impulse response with a small weight set
    coef[0] = 7; coef[1] = 56; coef[2] = 67; coef[3] = 18; coef[4] = -64; coef[5] = -118;
    load_filter(5);
    enter_run();
    run_sample(-2048, 0, "R11 impulse");
    for (int k = 1; k <= 6; k++) begin
      run_sample(0, 0, "R11 tail");
      chk("R11 direct", int'($signed(dataOut)), (k <= 5) ? -coef[k] : 0);
    end

    // R8 ordy held while idle-waiting
    repeat (5) @(negedge clk);
    chk("R8 hold", int'(resultVld), 1);

    // R2 R4 R5 R12 sweep over orders with pseudo-random weights and samples
    for (int n = 0; n <= 6; n++) begin
      runEn = 0;
      for (int k = 0; k <= n; k++) coef[k] = rnd12();
      load_filter(n);
      enter_run();
      for (int s = 0; s < 2 * n + 5; s++) run_sample(rnd12(), 0, "R4 R5 R12 sweep");
    end

    // R6 saturation positive and negative
    runEn = 0;
    for (int k = 0; k <= 3; k++) coef[k] = 2047;
    load_filter(3);
    enter_run();
    for (int s = 0; s < 4; s++) run_sample(2047, 0, "R6 pos");
    chk("R6 R7 pos clamp", int'($signed(dataOut)), 2047);
    for (int s = 0; s < 4; s++) run_sample(-2048, 0, "R6 neg");
    chk("R6 R7 neg clamp", int'($signed(dataOut)), -2048);

    // R9 sampleVld during MAC and during the ordy-setting cycle
    run_sample(100, 1, "R9 busy mac");
    run_sample(-300, 2, "R9 busy mac2");
    run_sample(555, order + 1, "R9 busy drain");
    run_sample(0, 0, "R9 after");

    // R10 exit with a coincident sampleVld, then re-enter keeps history
    @(negedge clk); runEn = 0; sampleVld = 1; dataIn = 12'h7ff;
    @(negedge clk); sampleVld = 0;
    chk("R10 ordy cleared", int'(resultVld), 0);
    repeat (3) @(negedge clk);
    chk("R10 stays idle", int'(resultVld), 0);
    enter_run();
    chk("R10 no stray result", int'(resultVld), 0);
    run_sample(-1000, 0, "R10 R4 history");
    run_sample(1234, 0, "R3 resume");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule